// File: doc/BRIEF.md
# Shift-Register Asynchronous Serial Transmitter

This block drives one asynchronous serial line at a fixed bit rate. A client offers a data word on `tx_data_i` and pulses or holds `tx_load_i`; when the block reports `tx_ready_o` high it takes the word. It then sends a frame on `txd_o` with one low start bit, the data bits least significant first, and one high stop bit. Between frames the line rests high.

The bit period is `CLKS_PER_BIT` clocks. For example, 3333 clocks gives 9600 baud from a 32 MHz clock, and 5208 clocks gives 9600 baud from 50 MHz. The frame is held in a shift register that moves toward the output pin and refills with ones from the top. Busy status does not use a bit counter. A second shift register of frame length is set to all ones when a word is taken, drains one zero per bit period, and its lowest bit is the busy flag. The bit-period counter is cleared whenever a word is taken, so the start bit is never cut short.

Top module: `sertx_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `txd_o` is 1 and `tx_ready_o` is 1 from the next cycle on.
- R2: Whenever `tx_ready_o` is 1, `txd_o` is 1 (the idle level).
- R3: A frame is a start bit of 0, then the DATA_W data bits with bit 0 first, then a stop bit of 1.
- R4: Every bit of a frame, the start bit included, lasts exactly CLKS_PER_BIT clocks, whatever the phase of the bit-period counter was when the word was taken.
- R5: After a word is taken, `tx_ready_o` is 0 for exactly (DATA_W+2)*CLKS_PER_BIT cycles and is 1 in the cycle after that.
- R6: A load request made while `tx_ready_o` is 0 is ignored. The current frame continues unchanged, and no extra frame follows it.
- R7: A load request seen at a clock edge while `tx_ready_o` is 1 takes the word, and the start bit appears on `txd_o` in the next cycle.
- R8: If `tx_load_i` is held high across frames, the next word is taken one cycle after `tx_ready_o` rises. Successive words are then taken (DATA_W+2)*CLKS_PER_BIT+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_load_i | input | 1 | Request to take `tx_data_i` |
| tx_data_i | input | DATA_W | Word to send |
| tx_ready_o | output | 1 | High when a new word can be taken |
| txd_o | output | 1 | Serial line, idles high |

## Verification
The bench decodes the line at mid-bit for several words, including 0x5A and 0x00. A wrong shift direction or a missing start bit would corrupt these words. It measures the start-bit length after an idle gap of arbitrary length. A design that kept a free-running counter without clearing it would give a short first bit there. It pokes a load with a different word in the middle of a frame. A design that honoured it would corrupt the byte or send a phantom frame. Back-to-back loads with the request held high check that the busy window is exactly ten bit periods, with a one-cycle handover between frames. A design that drained the busy register one bit early or late would break the frame spacing.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam logic LINE_IDLE  = 1'b1;
    localparam logic LINE_START = 1'b0;
    localparam logic LINE_STOP  = 1'b1;

    // Number of line bits around a data word: one start, one stop.
    localparam int FRAME_OVERHEAD = 2;

    function automatic int frame_bits(input int data_w);
        return data_w + FRAME_OVERHEAD;
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int CLKS_PER_BIT = 3333
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } baud_t;

    baud_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST) && !clr_i;

endmodule

// File: rtl/sertx_shreg.sv
module sertx_shreg #(
    parameter int         W       = 10,
    parameter logic       FILL    = 1'b0,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } shreg_t;

    shreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.bits = load_val_i;
        end else if (shift_i) begin
            st_d.bits = {FILL, st_q.bits[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bits <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 3333,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_load_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_ready_o,
    output logic              txd_o
);
    localparam int FW = frame_bits(DATA_W);

    logic          take;
    logic          tick;
    logic          step;
    logic [FW-1:0] frame_q;
    logic [FW-1:0] busy_q;
    logic [FW-1:0] frame_init;

    assign take       = tx_load_i && !busy_q[0];
    assign step       = tick && busy_q[0];
    assign frame_init = {LINE_STOP, tx_data_i, LINE_START};

    sertx_baud #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_baud (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (take),
        .tick_o (tick)
    );

    // Data path: shifts toward bit 0, refills with the idle level.
    sertx_shreg #(
        .W       (FW),
        .FILL    (LINE_IDLE),
        .RST_VAL ({FW{LINE_IDLE}})
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .load_i     (take),
        .load_val_i (frame_init),
        .shift_i    (step),
        .q_o        (frame_q)
    );

    // Busy tracker: loaded with ones, drains one zero per bit period.
    sertx_shreg #(
        .W       (FW),
        .FILL    (1'b0),
        .RST_VAL ('0)
    ) u_busy (
        .clk        (clk),
        .rst        (rst),
        .load_i     (take),
        .load_val_i ({FW{1'b1}}),
        .shift_i    (step),
        .q_o        (busy_q)
    );

    assign txd_o      = frame_q[0];
    assign tx_ready_o = !busy_q[0];

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
    parameter int CLKS_PER_BIT = 3333,
    parameter int DATA_W       = 8
) (
    input logic clk,
    input logic rst,
    input logic tx_load_i,
    input logic tx_ready_o,
    input logic txd_o
);
    localparam int FRAME_CYC = (DATA_W + 2) * CLKS_PER_BIT;
    localparam int EW        = $clog2(FRAME_CYC + 1);
    localparam int PW        = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;

    logic          accepted;
    logic          active_q;
    logic [EW-1:0] el_q;
    logic [PW-1:0] ph_q;

    assign accepted = tx_load_i && tx_ready_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            el_q     <= '0;
            ph_q     <= '0;
        end else if (accepted) begin
            active_q <= 1'b1;
            el_q     <= '0;
            ph_q     <= '0;
        end else if (active_q) begin
            if (el_q == EW'(FRAME_CYC)) begin
                active_q <= 1'b0;
            end else begin
                el_q <= el_q + 1'b1;
            end
            ph_q <= (ph_q == PW'(CLKS_PER_BIT - 1)) ? '0 : ph_q + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (tx_ready_o && txd_o));

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |-> txd_o);

    assert_start_bit_R7: assert property (@(posedge clk) disable iff (rst)
        accepted |=> (!txd_o && !tx_ready_o));

    assert_bit_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (active_q && el_q < EW'(FRAME_CYC) && ph_q != '0) |-> $stable(txd_o));

    assert_busy_window_R5: assert property (@(posedge clk) disable iff (rst)
        (active_q && el_q < EW'(FRAME_CYC)) |-> !tx_ready_o);

    assert_ready_return_R5: assert property (@(posedge clk) disable iff (rst)
        (active_q && el_q == EW'(FRAME_CYC)) |-> tx_ready_o);

endmodule

bind sertx_top sertx_checker #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_W      (DATA_W)
) u_sertx_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_load_i  (tx_load_i),
    .tx_ready_o (tx_ready_o),
    .txd_o      (txd_o)
);

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;
    localparam int DIV  = 16;
    localparam int HALF = DIV / 2;
    localparam int FCYC = 10 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_load_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic       tx_ready_o;
    logic       txd_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int acc_cyc = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sertx_top #(.CLKS_PER_BIT(DIV), .DATA_W(8)) uut (
        .clk        (clk),
        .rst        (rst),
        .tx_load_i  (tx_load_i),
        .tx_data_i  (tx_data_i),
        .tx_ready_o (tx_ready_o),
        .txd_o      (txd_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sends one word and decodes it at mid-bit. hold keeps the request high
    // with nxt for a back-to-back handover; poke issues an illegal mid-frame load.
    task automatic send_byte(input logic [7:0] b, input bit hold,
                             input logic [7:0] nxt, input bit poke);
        logic [9:0] got;
        tx_data_i = b;
        tx_load_i = 1'b1;
        while (!tx_ready_o) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        tx_load_i = 1'b0;
        chk(txd_o == 1'b0 && tx_ready_o == 1'b0, "R7 start bit after take", txd_o, 0);
        repeat (HALF) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            got[k] = txd_o;
            if (k < 9) begin
                if (poke && k == 3) begin
                    tx_data_i = 8'hFF;
                    tx_load_i = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    tx_load_i = 1'b0;
                    tx_data_i = b;
                    repeat (DIV - 1) @(posedge clk);
                end else begin
                    repeat (DIV) @(posedge clk);
                end
                @(negedge clk);
            end
        end
        chk(got[0] == 1'b0, "R3 start bit level", got[0], 0);
        chk(got[8:1] == b, poke ? "R6 byte kept despite busy load" : "R3 data bits lsb first",
            got[8:1], b);
        chk(got[9] == 1'b1, "R3 stop bit level", got[9], 1);
        repeat (DIV - HALF - 1) @(posedge clk);
        @(negedge clk);
        chk(tx_ready_o == 1'b0, "R5 busy through last cycle", tx_ready_o, 0);
        if (hold) begin
            tx_data_i = nxt;
            tx_load_i = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tx_ready_o == 1'b1, "R5 ready after ten bit periods", tx_ready_o, 1);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_ready_o == 1'b1, "R1 ready after reset", tx_ready_o, 1);
        chk(txd_o == 1'b1, "R1 line high after reset", txd_o, 1);
        repeat (5) @(negedge clk);
        chk(txd_o == 1'b1 && tx_ready_o == 1'b1, "R2 idle line high", txd_o, 1);
    endtask

    task automatic test_start_length(input int gap);
        int n;
        repeat (gap) @(negedge clk);
        tx_data_i = 8'hA5;
        tx_load_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_load_i = 1'b0;
        n = 0;
        while (txd_o == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == DIV, "R4 full start bit length", n, DIV);
        while (!tx_ready_o) @(negedge clk);
    endtask

    task automatic test_ignored_load();
        int highs;
        send_byte(8'h5A, 1'b0, 8'h00, 1'b1);
        highs = 0;
        for (int i = 0; i < 2 * DIV; i++) begin
            @(negedge clk);
            if (txd_o == 1'b1 && tx_ready_o == 1'b1) highs++;
        end
        chk(highs == 2 * DIV, "R6 no extra frame after busy load", highs, 2 * DIV);
    endtask

    task automatic test_back_to_back();
        int a1, a2;
        send_byte(8'h5A, 1'b1, 8'h00, 1'b0);
        a1 = acc_cyc;
        send_byte(8'h00, 1'b1, 8'hC3, 1'b0);
        a2 = acc_cyc;
        chk(a2 - a1 == FCYC + 1, "R8 back-to-back spacing", a2 - a1, FCYC + 1);
        send_byte(8'hC3, 1'b0, 8'h00, 1'b0);
        chk(acc_cyc - a2 == FCYC + 1, "R8 second handover spacing", acc_cyc - a2, FCYC + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        send_byte(8'h5A, 1'b0, 8'h00, 1'b0);
        send_byte(8'hFF, 1'b0, 8'h00, 1'b0);
        test_start_length(7);
        test_start_length(3);
        test_ignored_load();
        test_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule